// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block evaluates a comparison predicate between two single-precision binary floating-point operands and stores the one-bit outcome in a condition bit register. A requester presents both operands and a 4-bit condition code with a valid strobe. One clock later the block updates the condition bit, raises a one-cycle result-valid pulse and reports an invalid-operation flag.

The three low code bits choose which relations make the predicate true: unordered, equal and less. The code's top bit chooses how strictly NaN inputs are treated. In the quiet form, only a signaling NaN raises the invalid flag. In the signaling form, any NaN raises it. Every code inspects the operands' ordering, the constant-false one included, so that NaN detection happens whatever the predicate.

Top module: `fpcmp_unit`

## Requirements
- R1: A synchronous active-high reset clears cond_bit, res_valid and invalid to 0.
- R2: A valid strobe in cycle N makes res_valid high in cycle N+1 only, with cond_bit and invalid updated in that same cycle. With no strobe, res_valid and invalid are 0 and cond_bit holds its last value.
- R3: Bit 0 of the code selects unordered, bit 1 selects equal and bit 2 selects less. The predicate is the OR of the selected relations, so code 0 is always false and code 7 is "not greater".
- R4: An operand is NaN when its exponent field is all ones and its fraction is nonzero. A NaN in either operand makes the pair unordered, and then neither equal nor less holds.
- R5: Positive zero and negative zero compare equal, and neither is less than the other.
- R6: Ordered operands compare by sign and magnitude. A negative value is below any positive value, two negative values order by reversed magnitude, and infinities sit at the extremes.
- R7: With code bit 3 clear (quiet), invalid is raised only when an operand is a signaling NaN, meaning a NaN whose fraction MSB is 0.
- R8: With code bit 3 set (signaling), invalid is raised when either operand is any NaN. The predicate is the same as for the quiet code with equal low bits.
- R9: The always-false codes (0 and 8) still raise invalid under the NaN rules of R7 and R8, while cond_bit is written to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one comparison per high cycle |
| op_a | input | 32 | Left operand (A) |
| op_b | input | 32 | Right operand (B) |
| cond | input | 4 | Condition code: [2:0] relation mask, [3] signaling |
| cond_bit | output | 1 | Condition bit register |
| res_valid | output | 1 | One-cycle pulse marking an updated result |
| invalid | output | 1 | Invalid-operation flag, aligned with res_valid |

## Verification
Two outcomes land in the same cycle: the condition bit write and the invalid-operation flag. A NaN request therefore has to produce both a predicate value and an exception judgement on one edge. The bench provokes this with quiet and signaling NaNs under every code, including the always-false code. It judges both outputs in the pulse cycle against a reference model built on signed integer keys. It also drives back-to-back strobes, to show that a flag from one request does not persist into the next.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
   // relation bundle produced by the ordering stage
   typedef struct packed {
      logic lt;
      logic eq;
      logic un;
   } fpcmp_rel_t;

   localparam int CODE_W = 4;
   localparam int SIG_BIT = 3;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] val,
   output logic         sign,
   output logic [W-2:0] mag,
   output logic         is_zero,
   output logic         is_nan,
   output logic         is_snan
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   always_comb begin
      sign    = val[W-1];
      mag     = val[W-2:0];
      exp_f   = val[W-2 -: EXP_W];
      frac_f  = val[FRAC_W-1:0];
      is_zero = (mag == '0);
      is_nan  = (&exp_f) && (frac_f != '0);
      is_snan = is_nan && !frac_f[FRAC_W-1];
   end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
   import fpcmp_pkg::*;
#(
   parameter int MAG_W = 31
) (
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   input  logic             zero_a,
   input  logic             zero_b,
   input  logic             nan_a,
   input  logic             nan_b,
   output fpcmp_rel_t       rel
);
   logic same_val;
   logic a_below;

   always_comb begin
      rel.un   = nan_a | nan_b;
      same_val = (zero_a & zero_b) | ((sign_a == sign_b) & (mag_a == mag_b));
      if (sign_a != sign_b)
         a_below = sign_a;
      else if (sign_a)
         a_below = (mag_a > mag_b);
      else
         a_below = (mag_a < mag_b);
      rel.eq = !rel.un & same_val;
      rel.lt = !rel.un & !same_val & a_below;
   end
endmodule

// File: rtl/fpcmp_select.sv
module fpcmp_select
   import fpcmp_pkg::*;
(
   input  logic              [CODE_W-1:0] code,
   input  fpcmp_rel_t                     rel,
   input  logic                           any_nan,
   input  logic                           any_snan,
   output logic                           pred,
   output logic                           inv
);
   always_comb begin
      pred = (code[0] & rel.un) | (code[1] & rel.eq) | (code[2] & rel.lt);
      inv  = code[SIG_BIT] ? any_nan : any_snan;
   end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
   import fpcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [W-1:0]      op_a,
   input  logic [W-1:0]      op_b,
   input  logic [CODE_W-1:0] cond,
   output logic              cond_bit,
   output logic              res_valid,
   output logic              invalid
);
   generate
      if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_fmt
         $error("fpcmp_unit: EXP_W and FRAC_W must each be at least 2");
      end
   endgenerate

   logic [W-1:0] ops      [2];
   logic         sgn      [2];
   logic [W-2:0] mag      [2];
   logic         zro      [2];
   logic         nan      [2];
   logic         snan     [2];

   assign ops[0] = op_a;
   assign ops[1] = op_b;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_cls
         fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val     (ops[i]),
            .sign    (sgn[i]),
            .mag     (mag[i]),
            .is_zero (zro[i]),
            .is_nan  (nan[i]),
            .is_snan (snan[i])
         );
      end
   endgenerate

   fpcmp_rel_t rel;

   fpcmp_order #(.MAG_W(W-1)) u_ord (
      .sign_a (sgn[0]),
      .sign_b (sgn[1]),
      .mag_a  (mag[0]),
      .mag_b  (mag[1]),
      .zero_a (zro[0]),
      .zero_b (zro[1]),
      .nan_a  (nan[0]),
      .nan_b  (nan[1]),
      .rel    (rel)
   );

   logic pred_d;
   logic inv_d;

   fpcmp_select u_sel (
      .code     (cond),
      .rel      (rel),
      .any_nan  (nan[0] | nan[1]),
      .any_snan (snan[0] | snan[1]),
      .pred     (pred_d),
      .inv      (inv_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cond_bit  <= 1'b0;
         res_valid <= 1'b0;
         invalid   <= 1'b0;
      end else begin
         res_valid <= in_valid;
         invalid   <= in_valid & inv_d;
         if (in_valid)
            cond_bit <= pred_d;
      end
   end
endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic [3:0]   cond,
   input logic         cond_bit,
   input logic         res_valid,
   input logic         invalid
);
   logic a_nan, b_nan;
   assign a_nan = (&op_a[W-2 -: EXP_W]) && (op_a[FRAC_W-1:0] != '0);
   assign b_nan = (&op_b[W-2 -: EXP_W]) && (op_b[FRAC_W-1:0] != '0);

   // R2: pulse follows the strobe by exactly one cycle
   a_r2_pulse_on: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> res_valid);
   a_r2_pulse_off: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !res_valid && $stable(cond_bit));
   a_r2_inv_aligned: assert property (@(posedge clk) disable iff (rst)
      invalid |-> res_valid);
   // R3 / R9: constant-false codes never set the bit
   a_r3_false_code: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cond[2:0] == 3'd0) |=> !cond_bit);
   // R4: unordered pairs under the pure-unordered code give 1
   a_r4_unord: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cond[2:0] == 3'd1 && (a_nan || b_nan)) |=> cond_bit);
   // R8: signaling codes flag any NaN
   a_r8_sig_nan: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cond[3] && (a_nan || b_nan)) |=> invalid);
   // R4: no NaN, no flag
   a_r4_no_nan_no_flag: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !a_nan && !b_nan) |=> !invalid);
endmodule

bind fpcmp_unit fpcmp_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .cond      (cond),
   .cond_bit  (cond_bit),
   .res_valid (res_valid),
   .invalid   (invalid)
);

// File: tb/tb_fpcmp_unit.sv
module tb_fpcmp_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] op_a, op_b;
   logic [3:0]  cond;
   logic        cond_bit, res_valid, invalid;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   localparam logic [31:0] P1   = 32'h3F800000;
   localparam logic [31:0] P2   = 32'h40000000;
   localparam logic [31:0] N1   = 32'hBF800000;
   localparam logic [31:0] N2   = 32'hC0000000;
   localparam logic [31:0] PZ   = 32'h00000000;
   localparam logic [31:0] NZ   = 32'h80000000;
   localparam logic [31:0] PINF = 32'h7F800000;
   localparam logic [31:0] NINF = 32'hFF800000;
   localparam logic [31:0] QNAN = 32'h7FC00000;
   localparam logic [31:0] SNAN = 32'h7F800001;

   always #5 clk = ~clk;

   fpcmp_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .cond(cond), .cond_bit(cond_bit), .res_valid(res_valid), .invalid(invalid)
   );

   function automatic bit is_nan_f(input logic [31:0] v);
      return (v[30:23] == 8'hFF) && (v[22:0] != 0);
   endfunction

   // signed integer key: ordering of keys equals numeric ordering
   function automatic longint key_f(input logic [31:0] v);
      longint m = longint'(v[30:0]);
      return v[31] ? -m : m;
   endfunction

   function automatic bit exp_pred(input logic [31:0] a, b, input logic [3:0] c);
      bit u = is_nan_f(a) || is_nan_f(b);
      bit e = !u && key_f(a) == key_f(b);
      bit l = !u && key_f(a) <  key_f(b);
      return (c[0] && u) || (c[1] && e) || (c[2] && l);
   endfunction

   function automatic bit exp_inv(input logic [31:0] a, b, input logic [3:0] c);
      bit sa = is_nan_f(a) && !a[22];
      bit sb = is_nan_f(b) && !b[22];
      return c[3] ? (is_nan_f(a) || is_nan_f(b)) : (sa || sb);
   endfunction

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // one request, then check pulse, bit and flag in the following cycle
   task automatic cmp(input string req, input logic [31:0] a, b, input logic [3:0] c);
      @(negedge clk);
      op_a = a; op_b = b; cond = c; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(req, "res_valid", res_valid, 1'b1);
      chk(req, $sformatf("cond_bit a=%h b=%h c=%0d", a, b, c), cond_bit, exp_pred(a, b, c));
      chk(req, $sformatf("invalid a=%h b=%h c=%0d", a, b, c), invalid, exp_inv(a, b, c));
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; cond = '0;
      repeat (3) @(negedge clk);
      chk("R1", "cond_bit", cond_bit, 1'b0);
      chk("R1", "res_valid", res_valid, 1'b0);
      chk("R1", "invalid", invalid, 1'b0);
      rst = 1'b0;
   endtask

   task automatic t_codes();
      for (int c = 0; c < 8; c++) begin
         cmp("R3", P1, P2, 4'(c));
         cmp("R3", P2, P1, 4'(c));
         cmp("R3", P1, P1, 4'(c));
      end
   endtask

   task automatic t_nan();
      for (int c = 0; c < 8; c++) begin
         cmp("R4", QNAN, P1, 4'(c));
         cmp("R4", P1, QNAN, 4'(c));
      end
   endtask

   task automatic t_zero();
      cmp("R5", PZ, NZ, 4'd2);
      cmp("R5", NZ, PZ, 4'd4);
      cmp("R5", PZ, NZ, 4'd4);
      cmp("R5", NZ, P1, 4'd4);
   endtask

   task automatic t_signs();
      cmp("R6", N2, N1, 4'd4);
      cmp("R6", N1, N2, 4'd4);
      cmp("R6", N1, P1, 4'd4);
      cmp("R6", P1, N1, 4'd6);
      cmp("R6", NINF, N2, 4'd4);
      cmp("R6", P2, PINF, 4'd4);
      cmp("R6", PINF, PINF, 4'd2);
   endtask

   task automatic t_quiet();
      cmp("R7", QNAN, P1, 4'd2);
      cmp("R7", SNAN, P1, 4'd2);
      cmp("R7", P1, SNAN, 4'd5);
      cmp("R7", P1, P2, 4'd5);
   endtask

   task automatic t_signal();
      for (int c = 8; c < 16; c++) begin
         cmp("R8", QNAN, P1, 4'(c));
         cmp("R8", P1, P2, 4'(c));
      end
   endtask

   task automatic t_false();
      cmp("R9", SNAN, P1, 4'd0);
      cmp("R9", QNAN, P1, 4'd0);
      cmp("R9", QNAN, QNAN, 4'd8);
      cmp("R9", P1, P1, 4'd8);
   endtask

   task automatic t_hold();
      cmp("R2", P1, P1, 4'd10);
      @(negedge clk);
      chk("R2", "idle res_valid", res_valid, 1'b0);
      chk("R2", "idle cond_bit held", cond_bit, 1'b1);
      chk("R2", "idle invalid", invalid, 1'b0);
      // back-to-back: flag from the first must not persist into the second
      @(negedge clk);
      op_a = SNAN; op_b = P1; cond = 4'd0; in_valid = 1'b1;
      @(negedge clk);
      chk("R2", "b2b first invalid", invalid, 1'b1);
      op_a = P1; op_b = P2; cond = 4'd4;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2", "b2b second res_valid", res_valid, 1'b1);
      chk("R2", "b2b second invalid", invalid, 1'b0);
      chk("R2", "b2b second cond_bit", cond_bit, 1'b1);
   endtask

   initial begin
      t_reset();
      t_codes();
      t_nan();
      t_zero();
      t_signs();
      t_quiet();
      t_signal();
      t_false();
      t_hold();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule